// File: doc/BRIEF.md
# Lockable Pad Routing Multiplexer

This block connects a set of bidirectional pads to a set of peripherals. Every peripheral input has a select register that picks either a fixed level or one pad. Every pad has a select register that picks a fixed drive, high impedance, or one peripheral output together with that peripheral's output enable. A per-pad attribute word adds level inversion, virtual open drain and input disable on the digital path. It also stores pull, keeper, Schmitt, slew and drive settings, which are only read back.

Every select and attribute register has its own enable bit. Software clears the enable bit to freeze the register for the rest of the power cycle, and only reset can set it again. Configuration goes through a simple word-addressed register bus: one write strobe, and a read path that is purely combinational. Address bits [7:4] pick the register group and bits [3:0] the index: group 0 is input selects, 1 their enables, 2 pad selects, 3 their enables, 4 attributes, 5 their enables.

Top module: `pad_route_mux`

## Requirements
- R1: Input select code 0 gives constant 0 and code 1 gives constant 1. Code k+2 routes the conditioned level of pad k to the peripheral input.
- R2: Pad select code 0 drives 0, code 1 drives 1 and code 2 turns the driver off (pad_oe=0). Code k+3 passes peripheral output k and its enable to the pad.
- R3: A select value above the highest legal code is stored and reads back unchanged. An input route with such a value gives 0; a pad route with it behaves like code 0.
- R4: A register write takes effect at the clock edge where reg_wr is high. Reads are combinational and zero-extended. Select registers keep only their low clog2(count+reserved) bits. Unmapped groups and indices read 0, and writes to them change nothing.
- R5: After reset every enable bit reads 1. Writing 0 to an enable bit (wdata bit 0) clears it. Writing 1 to a cleared enable bit leaves it at 0 until the next reset.
- R6: While an enable bit is 0, writes to its select or attribute register are ignored.
- R7: Attribute bit 0 (invert) XORs both the pad level seen by input routes and the level driven onto the pad.
- R8: Attribute bit 1 (virtual open drain) forces pad_oe low whenever the pad output level after inversion is 1.
- R9: Attribute bit 7 (input disable) makes the pad look like 0 to every input route, with or without invert.
- R10: The attribute word keeps bits [13:8] (slew [9:8], drive [13:10]) and bits 0 to 5 and 7 as written. Bit 6 (true open drain) and bits 31:14 are not supported and read 0.
- R11: Reset (synchronous, rst_n low) clears input selects and attributes to 0 and sets pad selects to code 2, so every pad is released and every peripheral input sees 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word address: [7:4] group, [3:0] index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pad_in | input | NUM_PADS | Levels sampled at the pads |
| pad_out | output | NUM_PADS | Levels driven to the pads |
| pad_oe | output | NUM_PADS | Pad driver enables |
| periph_out | input | NUM_PERIPH_OUT | Peripheral output data |
| periph_oe | input | NUM_PERIPH_OUT | Peripheral output enables |
| periph_in | output | NUM_PERIPH_IN | Routed levels to peripheral inputs |

## Verification
The bench goes after the reserved low codes of both select types. A design that counted pads or peripherals from code 0 would route the wrong source, off by two or by three. It writes illegal select values and checks that they read back intact yet route a constant; a design that clamped or wrapped them would show a different read value or a live source. The lock scenarios try a rewrite of a cleared enable bit and then a write to the locked register; a design with a settable enable or a leaky guard would change the register. The attribute scenarios combine invert with virtual open drain and input disable, and write all ones to an attribute word. A design that applied invert after the open-drain test, or stored the unsupported bits, would give the wrong enable or read-back value.

// File: rtl/pad_route_pkg.sv
// Package: shared constants for the pad routing multiplexer.
// Assumes: word addressing with a 4-bit group field and a 4-bit index field.
package pad_route_pkg;

    localparam int unsigned IDX_W  = 4;
    localparam int unsigned ATTR_W = 14;

    localparam logic [3:0] GRP_INSEL     = 4'h0;
    localparam logic [3:0] GRP_INSEL_EN  = 4'h1;
    localparam logic [3:0] GRP_OUTSEL    = 4'h2;
    localparam logic [3:0] GRP_OUTSEL_EN = 4'h3;
    localparam logic [3:0] GRP_ATTR      = 4'h4;
    localparam logic [3:0] GRP_ATTR_EN   = 4'h5;

    localparam int unsigned ATB_INVERT  = 0;
    localparam int unsigned ATB_VOD     = 1;
    localparam int unsigned ATB_OD      = 6;
    localparam int unsigned ATB_IN_DIS  = 7;

    // Bits the attribute register keeps; open drain (bit 6) is not accepted.
    localparam logic [ATTR_W-1:0] ATTR_KEEP = 14'h3FBF;

    localparam int unsigned IN_RESERVED  = 2;
    localparam int unsigned OUT_RESERVED = 3;
    localparam int unsigned OUT_CODE_HIZ = 2;

endpackage

// File: rtl/pad_route_cfg.sv
// Module: configuration register file with per-register lock enables.
// Holds input selects, pad selects and pad attributes, each guarded by an
// enable bit that can only be cleared. Assumes counts of at most 16 each.
module pad_route_cfg
    import pad_route_pkg::*;
#(
    parameter int unsigned NP = 4,
    parameter int unsigned NI = 4,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 8,
    parameter int unsigned IW = 3,
    parameter int unsigned OW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    output logic [NI-1:0][IW-1:0] insel,
    output logic [NP-1:0][OW-1:0] outsel,
    output logic [NP-1:0]         inv,
    output logic [NP-1:0]         vod,
    output logic [NP-1:0]         in_dis
);

    logic [3:0]       grp;
    logic [IDX_W-1:0] idx;
    logic             unused_wdata;

    logic [NI-1:0][IW-1:0]     insel_q;
    logic [NI-1:0]             insel_en_q;
    logic [NP-1:0][OW-1:0]     outsel_q;
    logic [NP-1:0]             outsel_en_q;
    logic [NP-1:0][ATTR_W-1:0] attr_q;
    logic [NP-1:0]             attr_en_q;

    assign grp          = reg_addr[7:4];
    assign idx          = reg_addr[3:0];
    assign unused_wdata = ^reg_wdata[DW-1:ATTR_W];

    for (genvar i = 0; i < NI; i++) begin : g_in
        logic hit_sel, hit_en;
        assign hit_sel = reg_wr && grp == GRP_INSEL    && idx == IDX_W'(i);
        assign hit_en  = reg_wr && grp == GRP_INSEL_EN && idx == IDX_W'(i);

        // Input select and its lock bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                insel_q[i]    <= '0;
                insel_en_q[i] <= 1'b1;
            end else begin
                if (hit_sel && insel_en_q[i]) insel_q[i] <= reg_wdata[IW-1:0];
                if (hit_en && !reg_wdata[0])  insel_en_q[i] <= 1'b0;
            end
        end

        p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(insel_en_q[i]) |-> $stable(insel_q[i]));
        p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(insel_en_q[i]) |-> !insel_en_q[i]);
    end

    for (genvar p = 0; p < NP; p++) begin : g_pad
        logic hit_sel, hit_sel_en, hit_attr, hit_attr_en;
        assign hit_sel     = reg_wr && grp == GRP_OUTSEL    && idx == IDX_W'(p);
        assign hit_sel_en  = reg_wr && grp == GRP_OUTSEL_EN && idx == IDX_W'(p);
        assign hit_attr    = reg_wr && grp == GRP_ATTR      && idx == IDX_W'(p);
        assign hit_attr_en = reg_wr && grp == GRP_ATTR_EN   && idx == IDX_W'(p);

        // Pad select, attribute word and their lock bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                outsel_q[p]    <= OW'(OUT_CODE_HIZ);
                outsel_en_q[p] <= 1'b1;
                attr_q[p]      <= '0;
                attr_en_q[p]   <= 1'b1;
            end else begin
                if (hit_sel && outsel_en_q[p])   outsel_q[p] <= reg_wdata[OW-1:0];
                if (hit_sel_en && !reg_wdata[0]) outsel_en_q[p] <= 1'b0;
                if (hit_attr && attr_en_q[p])    attr_q[p] <= reg_wdata[ATTR_W-1:0] & ATTR_KEEP;
                if (hit_attr_en && !reg_wdata[0]) attr_en_q[p] <= 1'b0;
            end
        end

        p_out_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(outsel_en_q[p]) |-> $stable(outsel_q[p]));
        p_attr_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(attr_en_q[p]) |-> $stable(attr_q[p]));
        p_attr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(attr_en_q[p]) |-> !attr_en_q[p]);

        assign inv[p]    = attr_q[p][ATB_INVERT];
        assign vod[p]    = attr_q[p][ATB_VOD];
        assign in_dis[p] = attr_q[p][ATB_IN_DIS];
    end

    assign insel  = insel_q;
    assign outsel = outsel_q;

    // Combinational read of the addressed register, zero-extended.
    always_comb begin
        reg_rdata = '0;
        case (grp)
            GRP_INSEL:
                for (int i = 0; i < NI; i++) if (idx == IDX_W'(i)) reg_rdata = DW'(insel_q[i]);
            GRP_INSEL_EN:
                for (int i = 0; i < NI; i++) if (idx == IDX_W'(i)) reg_rdata = DW'(insel_en_q[i]);
            GRP_OUTSEL:
                for (int p = 0; p < NP; p++) if (idx == IDX_W'(p)) reg_rdata = DW'(outsel_q[p]);
            GRP_OUTSEL_EN:
                for (int p = 0; p < NP; p++) if (idx == IDX_W'(p)) reg_rdata = DW'(outsel_en_q[p]);
            GRP_ATTR:
                for (int p = 0; p < NP; p++) if (idx == IDX_W'(p)) reg_rdata = DW'(attr_q[p]);
            GRP_ATTR_EN:
                for (int p = 0; p < NP; p++) if (idx == IDX_W'(p)) reg_rdata = DW'(attr_en_q[p]);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pad_route_in.sv
// Module: routes conditioned pad levels to peripheral inputs.
// Codes 0 and 1 are constants, code k+2 is pad k, anything else gives 0.
module pad_route_in
    import pad_route_pkg::*;
#(
    parameter int unsigned NP = 4,
    parameter int unsigned NI = 4,
    parameter int unsigned IW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NP-1:0]         pad_in,
    input  logic [NP-1:0]         inv,
    input  logic [NP-1:0]         in_dis,
    input  logic [NI-1:0][IW-1:0] insel,
    output logic [NI-1:0]         periph_in
);

    logic [NP-1:0] pad_seen;

    // Apply input disable and inversion before any route looks at a pad.
    always_comb begin
        pad_seen = (pad_in ^ inv) & ~in_dis;
    end

    for (genvar i = 0; i < NI; i++) begin : g_route
        // Select one source for peripheral input i.
        always_comb begin
            periph_in[i] = 1'b0;
            if (insel[i] == IW'(1)) periph_in[i] = 1'b1;
            for (int k = 0; k < NP; k++) begin
                if (insel[i] == IW'(k + IN_RESERVED)) periph_in[i] = pad_seen[k];
            end
        end

        p_const_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (insel[i] == IW'(1)) |-> periph_in[i]);
        p_oob_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(insel[i]) >= NP + IN_RESERVED) |-> !periph_in[i]);
    end

    for (genvar k = 0; k < NP; k++) begin : g_dis_chk
        p_in_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_dis[k] && insel[0] == IW'(k + IN_RESERVED)) |-> !periph_in[0]);
    end

endmodule

// File: rtl/pad_route_out.sv
// Module: drives pads from a fixed level, high impedance or a peripheral.
// Codes 0/1/2 are drive 0, drive 1 and high-Z; code k+3 is peripheral k;
// illegal codes act as code 0. Invert and virtual open drain follow.
module pad_route_out
    import pad_route_pkg::*;
#(
    parameter int unsigned NP = 4,
    parameter int unsigned NO = 4,
    parameter int unsigned OW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NP-1:0][OW-1:0] outsel,
    input  logic [NO-1:0]         periph_out,
    input  logic [NO-1:0]         periph_oe,
    input  logic [NP-1:0]         inv,
    input  logic [NP-1:0]         vod,
    output logic [NP-1:0]         pad_out,
    output logic [NP-1:0]         pad_oe
);

    for (genvar p = 0; p < NP; p++) begin : g_pad
        logic raw_d, raw_oe;

        // Pick the raw level and enable for pad p.
        always_comb begin
            raw_d  = 1'b0;
            raw_oe = 1'b1;
            if (outsel[p] == OW'(1)) raw_d = 1'b1;
            if (outsel[p] == OW'(OUT_CODE_HIZ)) raw_oe = 1'b0;
            for (int k = 0; k < NO; k++) begin
                if (outsel[p] == OW'(k + OUT_RESERVED)) begin
                    raw_d  = periph_out[k];
                    raw_oe = periph_oe[k];
                end
            end
        end

        // Invert, then release the driver for a high level under virtual open drain.
        always_comb begin
            pad_out[p] = raw_d ^ inv[p];
            pad_oe[p]  = raw_oe & ~(vod[p] & pad_out[p]);
        end

        p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (outsel[p] == OW'(OUT_CODE_HIZ)) |-> !pad_oe[p]);
        p_vod_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (vod[p] && pad_out[p]) |-> !pad_oe[p]);
        p_oob_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(outsel[p]) >= NO + OUT_RESERVED && !vod[p]) |-> (pad_oe[p] && pad_out[p] == inv[p]));
    end

endmodule

// File: rtl/pad_route_mux.sv
// Module: top of the lockable pad routing multiplexer.
// Ties the register file to the input and output routing networks.
// Assumes each of NUM_PADS, NUM_PERIPH_IN, NUM_PERIPH_OUT is 16 or less.
module pad_route_mux #(
    parameter int unsigned NUM_PADS       = 4,
    parameter int unsigned NUM_PERIPH_IN  = 4,
    parameter int unsigned NUM_PERIPH_OUT = 4,
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned ADDR_W         = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    input  logic [NUM_PADS-1:0]       pad_in,
    output logic [NUM_PADS-1:0]       pad_out,
    output logic [NUM_PADS-1:0]       pad_oe,
    input  logic [NUM_PERIPH_OUT-1:0] periph_out,
    input  logic [NUM_PERIPH_OUT-1:0] periph_oe,
    output logic [NUM_PERIPH_IN-1:0]  periph_in
);

    localparam int unsigned IW = $clog2(NUM_PADS + pad_route_pkg::IN_RESERVED);
    localparam int unsigned OW = $clog2(NUM_PERIPH_OUT + pad_route_pkg::OUT_RESERVED);

    logic [NUM_PERIPH_IN-1:0][IW-1:0] insel;
    logic [NUM_PADS-1:0][OW-1:0]      outsel;
    logic [NUM_PADS-1:0]              inv, vod, in_dis;

    pad_route_cfg #(
        .NP(NUM_PADS), .NI(NUM_PERIPH_IN), .DW(DATA_W), .AW(ADDR_W), .IW(IW), .OW(OW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .insel(insel),
        .outsel(outsel), .inv(inv), .vod(vod), .in_dis(in_dis)
    );

    pad_route_in #(.NP(NUM_PADS), .NI(NUM_PERIPH_IN), .IW(IW)) u_in (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .inv(inv), .in_dis(in_dis),
        .insel(insel), .periph_in(periph_in)
    );

    pad_route_out #(.NP(NUM_PADS), .NO(NUM_PERIPH_OUT), .OW(OW)) u_out (
        .clk(clk), .rst_n(rst_n), .outsel(outsel), .periph_out(periph_out),
        .periph_oe(periph_oe), .inv(inv), .vod(vod), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    p_reset_release_r11: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && periph_in == '0));

endmodule

// File: tb/pad_route_mux_tb.sv
// Directed bench for pad_route_mux: one task per scenario, each self-checking.
module pad_route_mux_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pad_in = '0;
    logic [3:0]  pad_out, pad_oe;
    logic [3:0]  periph_out = '0;
    logic [3:0]  periph_oe = '0;
    logic [3:0]  periph_in;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pad_route_mux u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
        .periph_oe(periph_oe), .periph_in(periph_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        #1;
        chk("R11 pad_oe", 32'(pad_oe), 0);
        chk("R11 periph_in", 32'(periph_in), 0);
        rd(8'h00, v); chk("R11 insel0", v, 0);
        rd(8'h21, v); chk("R11 outsel1", v, 2);
        rd(8'h43, v); chk("R11 attr3", v, 0);
        rd(8'h10, v); chk("R5 insel_en0", v, 1);
        rd(8'h52, v); chk("R5 attr_en2", v, 1);
    endtask

    task automatic t_input_route();
        do_reset();
        pad_in = 4'b1010;
        wr(8'h00, 2); wr(8'h01, 3); wr(8'h02, 1); wr(8'h03, 5);
        #1;
        chk("R1 pattern 1010", 32'(periph_in), 32'b1110);
        pad_in = 4'b0101;
        #1;
        chk("R1 pattern 0101", 32'(periph_in), 32'b0101);
        wr(8'h02, 0);
        #1;
        chk("R1 code0 constant", 32'(periph_in[2]), 0);
    endtask

    task automatic t_output_route();
        do_reset();
        periph_out = 4'b0110; periph_oe = 4'b1101;
        wr(8'h20, 0); wr(8'h21, 1); wr(8'h22, 2); wr(8'h23, 4);
        #1;
        chk("R2 pad_out codes", 32'(pad_out & 4'b1011), 32'b1010);
        chk("R2 pad_oe codes", 32'(pad_oe), 32'b0011);
        wr(8'h23, 6);
        #1;
        chk("R2 periph3 out", 32'(pad_out[3]), 0);
        chk("R2 periph3 oe", 32'(pad_oe[3]), 1);
    endtask

    task automatic t_out_of_range();
        logic [31:0] v;
        do_reset();
        pad_in = 4'b1111;
        periph_out = 4'b1111; periph_oe = 4'b1111;
        wr(8'h00, 7); wr(8'h20, 7);
        rd(8'h00, v); chk("R3 insel readback", v, 7);
        rd(8'h20, v); chk("R3 outsel readback", v, 7);
        chk("R3 input route zero", 32'(periph_in[0]), 0);
        chk("R3 pad drive 0 out", 32'(pad_out[0]), 0);
        chk("R3 pad drive 0 oe", 32'(pad_oe[0]), 1);
    endtask

    task automatic t_reg_map();
        logic [31:0] v;
        do_reset();
        wr(8'h01, 32'hFFFF_FFFD);
        rd(8'h01, v); chk("R4 low bits kept", v, 5);
        wr(8'h05, 3);
        rd(8'h05, v); chk("R4 index beyond count", v, 0);
        wr(8'hF0, 32'hFFFF_FFFF);
        rd(8'hF0, v); chk("R4 unmapped group", v, 0);
        rd(8'h00, v); chk("R4 stray write harmless", v, 0);
    endtask

    task automatic t_invert();
        do_reset();
        pad_in = 4'b0000;
        wr(8'h41, 32'h1);
        wr(8'h00, 3); wr(8'h21, 0);
        #1;
        chk("R7 input inverted", 32'(periph_in[0]), 1);
        chk("R7 output inverted", 32'(pad_out[1]), 1);
        pad_in = 4'b0010;
        #1;
        chk("R7 input inverted high", 32'(periph_in[0]), 0);
    endtask

    task automatic t_vod();
        do_reset();
        wr(8'h42, 32'h2);
        wr(8'h22, 1);
        #1;
        chk("R8 high released", 32'(pad_oe[2]), 0);
        wr(8'h22, 0);
        #1;
        chk("R8 low driven", 32'(pad_oe[2]), 1);
        wr(8'h42, 32'h3);
        #1;
        chk("R8 low inverted released", 32'(pad_oe[2]), 0);
    endtask

    task automatic t_in_disable();
        do_reset();
        pad_in = 4'b1000;
        wr(8'h03, 5);
        #1;
        chk("R9 enabled baseline", 32'(periph_in[3]), 1);
        wr(8'h43, 32'h80);
        #1;
        chk("R9 disabled high", 32'(periph_in[3]), 0);
        wr(8'h43, 32'h81);
        pad_in = 4'b0000;
        #1;
        chk("R9 disabled with invert", 32'(periph_in[3]), 0);
    endtask

    task automatic t_attr_readback();
        logic [31:0] v;
        do_reset();
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R10 all ones", v, 32'h3FBF);
        wr(8'h40, 32'h40);
        rd(8'h40, v); chk("R10 open drain dropped", v, 0);
        wr(8'h40, 32'h2A14);
        rd(8'h40, v); chk("R10 analog fields", v, 32'h2A14);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 4);
        wr(8'h10, 0);
        rd(8'h10, v); chk("R5 cleared", v, 0);
        wr(8'h10, 1);
        rd(8'h10, v); chk("R5 rewrite one ignored", v, 0);
        wr(8'h00, 2);
        rd(8'h00, v); chk("R6 insel locked", v, 4);
        wr(8'h33, 0); wr(8'h23, 1);
        rd(8'h23, v); chk("R6 outsel locked", v, 2);
        wr(8'h51, 0); wr(8'h41, 1);
        rd(8'h41, v); chk("R6 attr locked", v, 0);
        wr(8'h01, 3);
        rd(8'h01, v); chk("R6 neighbour unlocked", v, 3);
        do_reset();
        rd(8'h10, v); chk("R5 reset reopens", v, 1);
        rd(8'h00, v); chk("R11 reset clears locked", v, 0);
    endtask

    initial begin
        t_reset();
        t_input_route();
        t_output_route();
        t_out_of_range();
        t_reg_map();
        t_invert();
        t_vod();
        t_in_disable();
        t_attr_readback();
        t_lock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule